// File: doc/BRIEF.md
# MDIO Management Master with Selectable Frame Clause

This block is a management-bus master for Ethernet PHYs. It produces the management clock and drives the bidirectional data line through a data-out and output-enable pair, with a separate input. It speaks both the short-frame format (one PHY address plus a register number) and the extended format (PHY address plus device address, where the register address is sent in a separate frame). One status bit chooses which format is used.

Software uses four 32-bit registers at word indices 12 to 15 of a small register window (byte offsets 0x30 to 0x3C). A write to one of these registers starts an address, write or read frame. Software then polls the busy bit. When busy clears, a read result is in the data register and the read-error bit shows whether a PHY answered. The clock divider and preamble suppression are programmable. Register writes are single-cycle with the word index on `reg_word`. Reads are combinational on `reg_rdata`.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word at index 12 reads 0x0000_0500 (divider 10, short format, preamble on, idle, no error). Control (index 13), data (index 14) and address (index 15) read 0. MDC and the output enable are low.
- R2: Status bits [15:7] hold the divider D. MDC runs only while busy, with a period of 2×(max(D,5)+1) clock cycles. A stored D below 5 behaves as 5 but reads back as written.
- R3: Status bit 0 is busy. A frame with preamble keeps busy high for exactly 2×64×(eff+1) cycles after the launching write, where eff is the effective divider. The frame is 32 ones, then start, opcode, PHY address (control [9:5]), register or device field (control [4:0]), turnaround 10 on writes, and 16 data bits, most significant bit first.
- R4: With status bit 5 set, the 32 ones are left out. The frame starts at the start field and busy lasts 2×32×(eff+1) cycles.
- R5: With status bit 6 set (extended format), writing the address register launches an address frame with start 00 and opcode 00 that carries the written 16 bits. With bit 6 clear, the write only stores the value and no frame starts.
- R6: Writing the data register launches a write frame. The start/opcode pair is 01/01 in short format and 00/01 in extended format.
- R7: Writing control with bit 15 set launches a read frame using the PHY and register fields of that same write. The opcode is 10 in short format and 11 in extended format. The line is released for the two turnaround bits and the 16 data bits. When busy clears, data register bits [15:0] hold the value sampled.
- R8: Status bit 1 is set when the line is not low at the rising MDC edge of the second turnaround bit of a read. It is cleared when the next frame launches.
- R9: While busy is set, writes to any of the four registers change nothing and launch nothing.
- R10: While driven, MDIO changes only on falling MDC edges. Read bits are sampled on rising edges.
- R11: When idle, the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wen | input | 1 | Register write strobe, one cycle per write |
| reg_word | input | 4 | Word index of the register accessed |
| reg_wdata | input | 16 | Write data (upper register halves are reserved) |
| reg_rdata | output | 32 | Read data of the register at `reg_word` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Output enable for the management data line |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or preamble start point shows up at the end of the frame: busy stays high for the wrong number of cycles, and the PHY sees a different count of rising MDC edges. A bad divider shows within one MDC period. A shift or field-packing fault shows in the first frame, in the bits captured at rising edges. A turnaround fault in a read shows in the capture pattern of the enable, in the error bit, or in the data word, as soon as busy clears. A write accepted while busy shows in the register values read back after the frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_LEN = 32;
  localparam int DATA_W    = 16;
  localparam int FIELD_W   = 5;
  localparam int RSV_WORDS = 12;
  localparam int W_STAT    = RSV_WORDS;
  localparam int W_CTL     = RSV_WORDS + 1;
  localparam int W_DATA    = RSV_WORDS + 2;
  localparam int W_ADDR    = RSV_WORDS + 3;
  localparam int B_BUSY    = 0;
  localparam int B_RDERR   = 1;
  localparam int B_NOPRE   = 5;
  localparam int B_EXT     = 6;
  localparam int B_DIV_LO  = 7;
  localparam int B_PORT_LO = 5;
  localparam int B_READ    = 15;

  typedef enum logic [1:0] {FK_ADDR, FK_WRITE, FK_READ} frame_kind_e;

  // Packs one management frame, most significant bit sent first.
  function automatic logic [FRAME_LEN-1:0] build_frame(
      input logic ext, input frame_kind_e kind,
      input logic [FIELD_W-1:0] port, input logic [FIELD_W-1:0] dev,
      input logic [DATA_W-1:0] payload);
    logic [1:0] st, op, ta;
    logic [DATA_W-1:0] pl;
    st = ext ? 2'b00 : 2'b01;
    case (kind)
      FK_ADDR:  op = 2'b00;
      FK_WRITE: op = 2'b01;
      default:  op = ext ? 2'b11 : 2'b10;
    endcase
    ta = (kind == FK_READ) ? 2'b11 : 2'b10;
    pl = (kind == FK_READ) ? '1 : payload;
    return {st, op, port, dev, ta, pl};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W   = 9,
  parameter int DIV_MIN = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             mdc,
  output logic             rise_evt,
  output logic             fall_evt
);
  // Half period in clock cycles minus one; small settings are raised.
  function automatic logic [DIV_W-1:0] half_limit(input logic [DIV_W-1:0] d);
    return (d < DIV_W'(DIV_MIN)) ? DIV_W'(DIV_MIN) : d;
  endfunction

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;
  logic             tc;

  assign lim      = half_limit(div_cfg);
  assign tc       = en && (cnt == lim);
  assign rise_evt = tc && !mdc;
  assign fall_evt = tc && mdc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tc) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  p_mdc_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(mdc));
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !mdc);
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 start_rd,
  input  logic                 skip_pre,
  input  logic [FRAME_LEN-1:0] frame_word,
  input  logic                 rise_evt,
  input  logic                 fall_evt,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 rd_err,
  output logic                 rd_load,
  output logic [DATA_W-1:0]    rd_word
);
  localparam int TOT   = 2 * FRAME_LEN;
  localparam int IDX_W = $clog2(TOT);
  localparam int POS_W = $clog2(FRAME_LEN);
  localparam int TA1   = FRAME_LEN - DATA_W - 2;
  localparam int TA2   = FRAME_LEN - DATA_W - 1;

  logic [TOT-1:0]    sh;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  rel;
  logic [POS_W-1:0]  fpos;
  logic              rd_q;
  logic              in_body;
  logic              last_bit;
  logic              released;
  logic [DATA_W-1:0] cap;

  assign rel      = idx - IDX_W'(FRAME_LEN);
  assign fpos     = rel[POS_W-1:0];
  assign in_body  = (idx >= IDX_W'(FRAME_LEN));
  assign last_bit = (idx == IDX_W'(TOT - 1));
  assign released = rd_q && in_body && (fpos >= POS_W'(TA1));

  assign mdio_o   = busy ? sh[TOT-1] : 1'b1;
  assign mdio_oe  = busy && !released;
  assign rd_load  = busy && rd_q && fall_evt && last_bit;
  assign rd_word  = cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      rd_q   <= 1'b0;
      rd_err <= 1'b0;
      idx    <= '0;
      sh     <= '1;
      cap    <= '0;
    end else if (start && !busy) begin
      busy   <= 1'b1;
      rd_q   <= start_rd;
      rd_err <= 1'b0;
      cap    <= '0;
      idx    <= skip_pre ? IDX_W'(FRAME_LEN) : '0;
      sh     <= skip_pre ? {frame_word, {FRAME_LEN{1'b1}}}
                         : {{FRAME_LEN{1'b1}}, frame_word};
    end else if (busy) begin
      if (rise_evt && rd_q && in_body) begin
        if (fpos == POS_W'(TA2)) rd_err <= mdio_i;
        else if (fpos > POS_W'(TA2)) cap <= {cap[DATA_W-2:0], mdio_i};
      end
      if (fall_evt) begin
        if (last_bit) begin
          busy <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
          sh  <= {sh[TOT-2:0], 1'b1};
        end
      end
    end
  end

  p_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> $stable(rd_q));
  p_err_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> !rd_err);
  p_drive_on_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$stable(mdio_o) |-> $past(fall_evt));
  p_load_at_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> !busy);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int AW      = 4,
  parameter int DIV_W   = 9,
  parameter int DIV_MIN = 5,
  parameter int DIV_RST = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wen,
  input  logic [AW-1:0] reg_word,
  input  logic [15:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  logic                 busy, rd_err, rd_load, rise_evt, fall_evt;
  logic [DATA_W-1:0]    rd_word;
  logic [DIV_W-1:0]     div_q;
  logic                 ext_q, nopre_q;
  logic [FIELD_W-1:0]   port_q, dev_q, f_port, f_dev;
  logic [DATA_W-1:0]    data_q, addr_q;
  logic                 wr_ok, hit_stat, hit_ctl, hit_data, hit_addr;
  logic                 go_rd, go_wr, go_ad, go;
  frame_kind_e          kind;
  logic [FRAME_LEN-1:0] fword;

  assign wr_ok    = reg_wen && !busy;
  assign hit_stat = (reg_word == AW'(W_STAT));
  assign hit_ctl  = (reg_word == AW'(W_CTL));
  assign hit_data = (reg_word == AW'(W_DATA));
  assign hit_addr = (reg_word == AW'(W_ADDR));
  assign go_rd    = wr_ok && hit_ctl && reg_wdata[B_READ];
  assign go_wr    = wr_ok && hit_data;
  assign go_ad    = wr_ok && hit_addr && ext_q;
  assign go       = go_rd || go_wr || go_ad;
  assign f_port   = go_rd ? reg_wdata[B_PORT_LO +: FIELD_W] : port_q;
  assign f_dev    = go_rd ? reg_wdata[FIELD_W-1:0] : dev_q;
  assign kind     = go_rd ? FK_READ : (go_ad ? FK_ADDR : FK_WRITE);
  assign fword    = build_frame(ext_q, kind, f_port, f_dev, reg_wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q   <= DIV_W'(DIV_RST);
      ext_q   <= 1'b0;
      nopre_q <= 1'b0;
      port_q  <= '0;
      dev_q   <= '0;
      data_q  <= '0;
      addr_q  <= '0;
    end else begin
      if (wr_ok && hit_stat) begin
        div_q   <= reg_wdata[B_DIV_LO +: DIV_W];
        ext_q   <= reg_wdata[B_EXT];
        nopre_q <= reg_wdata[B_NOPRE];
      end
      if (wr_ok && hit_ctl) begin
        port_q <= reg_wdata[B_PORT_LO +: FIELD_W];
        dev_q  <= reg_wdata[FIELD_W-1:0];
      end
      if (wr_ok && hit_addr) addr_q <= reg_wdata;
      if (wr_ok && hit_data) data_q <= reg_wdata;
      else if (rd_load)      data_q <= rd_word;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_stat) begin
      reg_rdata[B_BUSY]              = busy;
      reg_rdata[B_RDERR]             = rd_err;
      reg_rdata[B_NOPRE]             = nopre_q;
      reg_rdata[B_EXT]               = ext_q;
      reg_rdata[B_DIV_LO +: DIV_W]   = div_q;
    end else if (hit_ctl) begin
      reg_rdata[B_PORT_LO +: FIELD_W] = port_q;
      reg_rdata[FIELD_W-1:0]          = dev_q;
    end else if (hit_data) begin
      reg_rdata[DATA_W-1:0] = data_q;
    end else if (hit_addr) begin
      reg_rdata[DATA_W-1:0] = addr_q;
    end
  end

  mdio_clkgen #(.DIV_W(DIV_W), .DIV_MIN(DIV_MIN)) u_clk (
    .clk(clk), .rst_n(rst_n), .en(busy), .div_cfg(div_q),
    .mdc(mdc), .rise_evt(rise_evt), .fall_evt(fall_evt)
  );

  mdio_frame u_frame (
    .clk(clk), .rst_n(rst_n), .start(go), .start_rd(go_rd),
    .skip_pre(nopre_q), .frame_word(fword), .rise_evt(rise_evt),
    .fall_evt(fall_evt), .mdio_i(mdio_i), .busy(busy), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .rd_err(rd_err), .rd_load(rd_load), .rd_word(rd_word)
  );

  p_busy_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && reg_wen |=> $stable(div_q) && $stable(port_q) && $stable(dev_q)
                        && $stable(addr_q) && $stable(ext_q) && $stable(nopre_q));
  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !go |=> !mdio_oe);
endmodule

// File: tb/sim_mdio_master.sv
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [3:0]  reg_word = 4'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int total = 0, bad = 0, cyc_now = 0, rises = 0, base = 0, tb_pre = 32;
  int r10_viol = 0, last_t0 = 0;
  logic [63:0] cap_d = '0, cap_oe = '0;
  logic        phy_on = 1'b1;
  logic [15:0] phy_data = 16'h0;
  logic        p_mdc = 1'b0, p_o = 1'b1, p_oe = 1'b0;

  mdio_master u0 (.clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_word(reg_word),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc_now <= cyc_now + 1;
    if (cyc_now > 150000) begin
      total++; bad++;
      $display("FAIL watchdog all-reqs actual=%0d expected=<150000", cyc_now);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // PHY side: capture on rising MDC, answer after falling MDC.
  always @(posedge mdc) begin
    rises  <= rises + 1;
    cap_d  <= {cap_d[62:0], mdio_o};
    cap_oe <= {cap_oe[62:0], mdio_oe};
  end
  always @(negedge mdc) begin
    int nb;
    nb = rises - base - tb_pre;
    if (!phy_on) mdio_i <= 1'b1;
    else if (nb == 15) mdio_i <= 1'b0;
    else if (nb >= 16 && nb <= 31) mdio_i <= phy_data[31-nb];
    else mdio_i <= 1'b1;
  end

  // R10 monitor: a driven line may change only where MDC has just fallen.
  always @(negedge clk) begin
    if (rst_n && p_oe && mdio_oe && (mdio_o != p_o) && !(p_mdc && !mdc))
      r10_viol++;
    p_mdc = mdc; p_o = mdio_o; p_oe = mdio_oe;
  end

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w, input logic [15:0] d);
    @(negedge clk); reg_wen = 1'b1; reg_word = w; reg_wdata = d;
    @(negedge clk); reg_wen = 1'b0; last_t0 = cyc_now;
  endtask

  task automatic rd(input logic [3:0] w, output logic [31:0] v);
    @(negedge clk); reg_word = w; #1 v = reg_rdata;
  endtask

  task automatic wait_idle(input int t0, output int cyc);
    logic [31:0] s;
    s = 32'h1;
    while (s[0]) rd(4'd12, s);
    cyc = cyc_now - t0;
  endtask

  function automatic logic [31:0] fr(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] p, input logic [4:0] d, input logic [1:0] ta, input logic [15:0] v);
    return {st, op, p, d, ta, v};
  endfunction

  task automatic launch(input logic [3:0] w, input logic [15:0] d, input int pre);
    tb_pre = pre; base = rises; wr(w, d);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd12, v); chk("R1 status", v, 32'h500);
    rd(4'd13, v); chk("R1 control", v, 0);
    rd(4'd14, v); chk("R1 data", v, 0);
    rd(4'd15, v); chk("R1 address", v, 0);
    chk("R1 mdc", mdc, 0);
    chk("R11 oe idle", mdio_oe, 0);
  endtask

  task automatic t_short_write;
    int c;
    wr(4'd12, 16'h0280); wr(4'd13, 16'h0071);   // port 3, reg 0x11
    launch(4'd14, 16'hA5C3, 32); wait_idle(last_t0, c);
    chk("R3 busy cycles", c, 768);
    chk("R3 rises", rises - base, 64);
    chk("R3 preamble", cap_d[63:32], 32'hFFFF_FFFF);
    chk("R6 short write frame", cap_d[31:0], fr(2'b01, 2'b01, 5'd3, 5'h11, 2'b10, 16'hA5C3));
    chk("R3 enable all bits", cap_oe, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R11 oe after", mdio_oe, 0);
    chk("R10 change points", r10_viol, 0);
  endtask

  task automatic t_no_preamble;
    int c;
    wr(4'd12, 16'h02A0);
    launch(4'd14, 16'h0F0F, 0); wait_idle(last_t0, c);
    chk("R4 busy cycles", c, 384);
    chk("R4 rises", rises - base, 32);
    chk("R4 frame", cap_d[31:0], fr(2'b01, 2'b01, 5'd3, 5'h11, 2'b10, 16'h0F0F));
  endtask

  task automatic t_extended;
    int c; logic [31:0] v;
    wr(4'd12, 16'h02C0); wr(4'd13, 16'h0025);   // port 1, device 5
    launch(4'd15, 16'h1234, 32); wait_idle(last_t0, c);
    chk("R5 addr frame cycles", c, 768);
    chk("R5 addr frame", cap_d[31:0], fr(2'b00, 2'b00, 5'd1, 5'd5, 2'b10, 16'h1234));
    launch(4'd14, 16'hBEEF, 32); wait_idle(last_t0, c);
    chk("R6 ext write frame", cap_d[31:0], fr(2'b00, 2'b01, 5'd1, 5'd5, 2'b10, 16'hBEEF));
    phy_on = 1'b1; phy_data = 16'h5A0F;
    launch(4'd13, 16'h8025, 32); wait_idle(last_t0, c);
    chk("R7 ext read header", cap_d[31:18], {2'b00, 2'b11, 5'd1, 5'd5});
    chk("R7 ext read release", cap_oe[31:0], 32'hFFFC_0000);
    rd(4'd14, v); chk("R7 ext read data", v, 32'h5A0F);
    rd(4'd12, v); chk("R8 no error", v[1], 0);
    // short format: address write only stores
    wr(4'd12, 16'h0280); base = rises; wr(4'd15, 16'h00F0);
    rd(4'd12, v); chk("R5 short addr no launch", v[0], 0);
    rd(4'd15, v); chk("R5 short addr stored", v, 32'h00F0);
    repeat (20) @(negedge clk);
    chk("R5 no mdc edges", rises - base, 0);
  endtask

  task automatic t_short_read;
    int c; logic [31:0] v;
    phy_on = 1'b1; phy_data = 16'h1234;
    launch(4'd13, 16'h8043, 32); wait_idle(last_t0, c);   // port 2, reg 3
    chk("R7 short read header", cap_d[31:18], {2'b01, 2'b10, 5'd2, 5'd3});
    chk("R7 short read release", cap_oe[31:0], 32'hFFFC_0000);
    rd(4'd14, v); chk("R7 short read data", v, 32'h1234);
    rd(4'd13, v); chk("R7 control fields", v, 32'h0043);
    chk("R10 read frame", r10_viol, 0);
  endtask

  task automatic t_read_error;
    int c; logic [31:0] v;
    phy_on = 1'b0;
    launch(4'd13, 16'h8043, 32); wait_idle(last_t0, c);
    rd(4'd12, v); chk("R8 error set", v[1], 1);
    rd(4'd14, v); chk("R8 data all ones", v, 32'hFFFF);
    phy_on = 1'b1;
    launch(4'd14, 16'h0001, 32);
    rd(4'd12, v); chk("R8 busy on launch", v[0], 1); chk("R8 error cleared", v[1], 0);
    wait_idle(last_t0, c);
  endtask

  task automatic t_busy_ignore;
    int c, t0; logic [31:0] v;
    launch(4'd14, 16'h1111, 32); t0 = last_t0;
    repeat (50) @(negedge clk);
    wr(4'd14, 16'h2222); wr(4'd13, 16'h83FF); wr(4'd12, 16'hFFE0); wr(4'd15, 16'h5555);
    wait_idle(t0, c);
    chk("R9 frame length", c, 768);
    chk("R9 frame payload", cap_d[31:0], fr(2'b01, 2'b01, 5'd2, 5'd3, 2'b10, 16'h1111));
    rd(4'd14, v); chk("R9 data kept", v, 32'h1111);
    rd(4'd13, v); chk("R9 control kept", v, 32'h0043);
    rd(4'd12, v); chk("R9 status kept", v, 32'h0280);
    rd(4'd15, v); chk("R9 address kept", v, 32'h00F0);
  endtask

  task automatic measure(input int exp_per, input int exp_cyc, input int pre, input string req);
    int c; time t1, t2;
    launch(4'd14, 16'h3C3C, pre);
    @(posedge mdc); t1 = $time; @(posedge mdc); t2 = $time;
    chk(req, (t2 - t1) / 10, exp_per);
    wait_idle(last_t0, c);
    chk(req, c, exp_cyc);
  endtask

  task automatic t_divider;
    logic [31:0] v;
    wr(4'd12, 16'h0100);                 // divider 2, raised to 5
    rd(4'd12, v); chk("R2 raw readback", v, 32'h0100);
    measure(12, 768, 32, "R2 clamped");
    wr(4'd12, 16'h03A0);                 // divider 7, no preamble
    measure(16, 512, 0, "R2 divider 7");
    chk("R2 mdc idle", mdc, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_short_write();
    t_no_preamble();
    t_extended();
    t_short_read();
    t_read_error();
    t_busy_ignore();
    t_divider();
    chk("R10 overall", r10_viol, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule